// File: doc/BRIEF.md
# Message-Aware Receive Buffer for a Crypto Engine

This block is a 32-word, 32-bit staging buffer that sits between a host register port and the input side of a crypto engine. The host, or a DMA channel acting for it, writes data words into a write window. The block holds the words and releases them to the selected engine in whole blocks. It keeps releasing blocks until a programmed message length has been delivered. The engine signals through a block-ready input that it can take a block. Once a block has started, its words leave on consecutive cycles.

Software configures the block through a few registers: a control word, a total length, a block size, and a destination address that is passed through to the engine. A running count of delivered words can be read back. The control read also reports how many words can still be written, plus done and overflow flags. The control word chooses one of three engines. For the hashing engine, the final word carries a last marker and a code that says which byte of that word is the last valid one.

Top module: `rx_msg_fifo`

## Requirements
- R1: After reset, and after any write to offset 0x00 with bit 2 set (flush), the following hold: the buffer is empty, the delivered count is 0, the done and overflow flags are clear, and the start bit (bit 0) reads 0.
- R2: A read of offset 0x00 returns the number of free words (32 minus the stored words) in bits [23:16], the done flag in bit 8, the overflow flag in bit 9, and the stored control byte in bits [7:0].
- R3: A write to any byte offset from 0x40 to 0xBF stores one word in arrival order, but only when control bit 5 (write enable) is 1. When bit 5 is 0, the word is dropped and the overflow flag is not changed.
- R4: A window write made while no word is free is dropped, and it sets the overflow flag.
- R5: A block starts only when all of these hold: control bit 0 is 1, done is clear, `eng_blk_ready` is 1, and the buffer holds at least the block length. The block length is the smaller of the block size and the words still owed. The words of a block appear on `eng_valid` on consecutive cycles, in write order.
- R6: When fewer words are owed than the block size, the final block is exactly the remaining tail.
- R7: The block size is the value in bits [15:0] of offset 0x08, counted in words. A size of 0 acts as 1, and a size above 32 acts as 32.
- R8: The count at offset 0x10 rises by one for each word delivered. When it equals the length at offset 0x04, the done flag sets and no further words are delivered.
- R9: A control write that moves bit 0 from 0 to 1 (with bit 2 clear) clears the count and the done flag, so that a new message can be delivered from the words already buffered.
- R10: `eng_sel` shows control bits [7:6] (0 AES, 1 DES/3DES, 2 hash). With destination 2, the final word of the message has `eng_last`=1 and `eng_vbytes` equal to bits [17:16] of offset 0x08 (0 to 3 mean bytes 1 to 4). On every other word `eng_vbytes` is 3, and with any other destination `eng_last` stays 0.
- R11: Offsets 0x04, 0x08 (bits [17:0]) and 0x0C read back what was written. The value at 0x0C is driven on `eng_dst`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register or window write strobe |
| reg_addr | input | 8 | Byte offset |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr (combinational) |
| eng_blk_ready | input | 1 | Engine can accept a block |
| eng_valid | output | 1 | A word is delivered this cycle |
| eng_data | output | 32 | Delivered word |
| eng_sel | output | 2 | Destination engine |
| eng_last | output | 1 | Final word of a hash message |
| eng_vbytes | output | 2 | Last valid byte code of the word |
| eng_dst | output | 32 | Engine input destination address |

## Verification
A wrong pointer or occupancy value appears at the ports on the very next delivered word. The effect is out-of-order or repeated data, and the free field at offset 0x00 disagrees with the number of words written minus the number delivered. A miscounted block length shows up as a burst on `eng_valid` whose run length differs from the programmed block or tail. A count or done error shows as words delivered after the message should have ended, or as a message that never finishes. Mistakes in the last flag and in the valid-byte code show on the final hash word itself.

// File: rtl/rxq_pkg.sv
package rxq_pkg;

    typedef enum logic [1:0] {
        DST_AES  = 2'd0,
        DST_DES  = 2'd1,
        DST_HASH = 2'd2,
        DST_RSVD = 2'd3
    } dest_e;

    // control byte, msb first: [7:6] dest, 5 wr_en, 4 rd_en, 3 sync, 2 flush, 1 spare, 0 start
    typedef struct packed {
        dest_e dest;
        logic  wr_en;
        logic  rd_en;
        logic  sync;
        logic  flush;
        logic  spare;
        logic  start;
    } ctrl_t;

    localparam logic [7:0] OFS_CTRL = 8'h00;
    localparam logic [7:0] OFS_LEN  = 8'h04;
    localparam logic [7:0] OFS_BLK  = 8'h08;
    localparam logic [7:0] OFS_DST  = 8'h0C;
    localparam logic [7:0] OFS_CNT  = 8'h10;

    localparam int FLUSH_BIT = 2;
    localparam int START_BIT = 0;

    function automatic logic in_window(input logic [7:0] a);
        return (a[7:6] == 2'b01) || (a[7:6] == 2'b10);
    endfunction

endpackage

// File: rtl/rxq_store.sv
module rxq_store #(
    parameter int DEPTH = 32,
    parameter int DW    = 32,
    localparam int PW   = $clog2(DEPTH),
    localparam int FW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          flush,
    input  logic          push,
    input  logic [DW-1:0] wdata,
    input  logic          pop,
    output logic [DW-1:0] head,
    output logic [FW-1:0] fill
);

    logic [DW-1:0] mem [DEPTH];
    logic [PW-1:0] wr_ptr, rd_ptr;
    logic          accept;

    assign accept = push && (fill != FW'(DEPTH));
    assign head   = mem[rd_ptr];

    function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
        return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_ff @(posedge clk) begin
        if (accept) mem[wr_ptr] <= wdata;
    end

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            fill   <= '0;
        end else begin
            if (accept) wr_ptr <= bump(wr_ptr);
            if (pop)    rd_ptr <= bump(rd_ptr);
            fill <= fill + FW'(accept) - FW'(pop);
        end
    end

    // R2: occupancy never exceeds capacity
    a_r2_fill_bound: assert property (@(posedge clk) disable iff (rst)
        fill <= FW'(DEPTH));

    // R5: a word is only delivered from a non-empty buffer
    a_r5_pop_has_data: assert property (@(posedge clk) disable iff (rst)
        pop |-> (fill != '0));

endmodule

// File: rtl/rxq_regs.sv
module rxq_regs
    import rxq_pkg::*;
#(
    parameter int DEPTH = 32,
    parameter int DW    = 32,
    localparam int FW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          reg_wr,
    input  logic [7:0]    reg_addr,
    input  logic [DW-1:0] reg_wdata,
    output logic [DW-1:0] reg_rdata,
    input  logic [FW-1:0] fill,
    input  logic [DW-1:0] count,
    input  logic          done,
    output ctrl_t         ctrl,
    output logic [DW-1:0] msg_len,
    output logic [15:0]   blk_size,
    output logic [1:0]    vcode,
    output logic [DW-1:0] dst_addr,
    output logic          flush,
    output logic          restart,
    output logic          win_push
);

    localparam logic [7:0] CLR_MASK = 8'hFA;

    logic       ctrl_wr;
    logic       ovf_q;
    logic [7:0] free_words;

    assign ctrl_wr    = reg_wr && (reg_addr == OFS_CTRL);
    assign flush      = ctrl_wr && reg_wdata[FLUSH_BIT];
    assign restart    = ctrl_wr && !reg_wdata[FLUSH_BIT] && reg_wdata[START_BIT] && !ctrl.start;
    assign win_push   = reg_wr && in_window(reg_addr) && ctrl.wr_en;
    assign free_words = 8'(DEPTH) - 8'(fill);

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl     <= '0;
            msg_len  <= '0;
            blk_size <= '0;
            vcode    <= '0;
            dst_addr <= '0;
        end else if (reg_wr) begin
            unique case (reg_addr)
                OFS_CTRL: ctrl <= reg_wdata[FLUSH_BIT] ? ctrl_t'(reg_wdata[7:0] & CLR_MASK)
                                                        : ctrl_t'(reg_wdata[7:0]);
                OFS_LEN:  msg_len <= reg_wdata;
                OFS_BLK: begin
                    blk_size <= reg_wdata[15:0];
                    vcode    <= reg_wdata[17:16];
                end
                OFS_DST:  dst_addr <= reg_wdata;
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst || flush)                           ovf_q <= 1'b0;
        else if (win_push && fill == FW'(DEPTH))    ovf_q <= 1'b1;
    end

    always_comb begin
        reg_rdata = '0;
        unique case (reg_addr)
            OFS_CTRL: begin
                reg_rdata[7:0]   = ctrl;
                reg_rdata[8]     = done;
                reg_rdata[9]     = ovf_q;
                reg_rdata[23:16] = free_words;
            end
            OFS_LEN: reg_rdata = msg_len;
            OFS_BLK: begin
                reg_rdata[15:0]  = blk_size;
                reg_rdata[17:16] = vcode;
            end
            OFS_DST: reg_rdata = dst_addr;
            OFS_CNT: reg_rdata = count;
            default: reg_rdata = '0;
        endcase
    end

endmodule

// File: rtl/rxq_sched.sv
module rxq_sched
    import rxq_pkg::*;
#(
    parameter int DEPTH = 32,
    parameter int DW    = 32,
    localparam int FW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          flush,
    input  logic          restart,
    input  ctrl_t         ctrl,
    input  logic [DW-1:0] msg_len,
    input  logic [15:0]   blk_size,
    input  logic [1:0]    vcode,
    input  logic [FW-1:0] fill,
    input  logic          eng_blk_ready,
    output logic          pop,
    output logic          eng_last,
    output logic [1:0]    eng_vbytes,
    output logic [DW-1:0] count,
    output logic          done
);

    logic          bursting_q;
    logic [FW-1:0] left_q;
    logic [DW-1:0] remaining;
    logic [FW-1:0] blk_eff, need;
    logic          owed, can_go, final_word;

    assign owed      = count < msg_len;
    assign remaining = msg_len - count;

    always_comb begin
        if (blk_size == 16'd0)              blk_eff = FW'(1);
        else if (blk_size > 16'(DEPTH))     blk_eff = FW'(DEPTH);
        else                                blk_eff = FW'(blk_size);
        need = (remaining < DW'(blk_eff)) ? FW'(remaining) : blk_eff;
    end

    assign can_go = ctrl.start && !done && !bursting_q && eng_blk_ready && owed && (fill >= need);

    always_ff @(posedge clk) begin
        if (rst || flush || restart) begin
            bursting_q <= 1'b0;
            left_q     <= '0;
            count      <= '0;
            done       <= 1'b0;
        end else begin
            if (bursting_q) begin
                count  <= count + 1'b1;
                left_q <= left_q - 1'b1;
                if (left_q == FW'(1)) bursting_q <= 1'b0;
            end else if (can_go) begin
                bursting_q <= 1'b1;
                left_q     <= need;
            end
            if (ctrl.start && !bursting_q && !owed) done <= 1'b1;
        end
    end

    assign pop        = bursting_q;
    assign final_word = bursting_q && (count + 1'b1 == msg_len);
    assign eng_last   = final_word && (ctrl.dest == DST_HASH);
    assign eng_vbytes = eng_last ? vcode : 2'd3;

    // R8: nothing is delivered once the message is complete
    a_r8_no_push_after_done: assert property (@(posedge clk) disable iff (rst)
        done |-> !pop);

    // R10: the marked final word closes its block
    a_r10_last_ends_burst: assert property (@(posedge clk) disable iff (rst || flush || restart)
        eng_last |=> !pop);

endmodule

// File: rtl/rx_msg_fifo.sv
module rx_msg_fifo
    import rxq_pkg::*;
#(
    parameter int DEPTH = 32,
    parameter int DW    = 32,
    localparam int FW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          reg_wr,
    input  logic [7:0]    reg_addr,
    input  logic [DW-1:0] reg_wdata,
    output logic [DW-1:0] reg_rdata,
    input  logic          eng_blk_ready,
    output logic          eng_valid,
    output logic [DW-1:0] eng_data,
    output logic [1:0]    eng_sel,
    output logic          eng_last,
    output logic [1:0]    eng_vbytes,
    output logic [DW-1:0] eng_dst
);

    ctrl_t         ctrl;
    logic [DW-1:0] msg_len, count;
    logic [15:0]   blk_size;
    logic [1:0]    vcode;
    logic          flush, restart, win_push, pop, done;
    logic [FW-1:0] fill;

    rxq_regs #(.DEPTH(DEPTH), .DW(DW)) regs_i (
        .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .fill(fill),
        .count(count), .done(done), .ctrl(ctrl), .msg_len(msg_len),
        .blk_size(blk_size), .vcode(vcode), .dst_addr(eng_dst),
        .flush(flush), .restart(restart), .win_push(win_push)
    );

    rxq_store #(.DEPTH(DEPTH), .DW(DW)) store_i (
        .clk(clk), .rst(rst), .flush(flush), .push(win_push),
        .wdata(reg_wdata), .pop(pop), .head(eng_data), .fill(fill)
    );

    rxq_sched #(.DEPTH(DEPTH), .DW(DW)) sched_i (
        .clk(clk), .rst(rst), .flush(flush), .restart(restart), .ctrl(ctrl),
        .msg_len(msg_len), .blk_size(blk_size), .vcode(vcode), .fill(fill),
        .eng_blk_ready(eng_blk_ready), .pop(pop), .eng_last(eng_last),
        .eng_vbytes(eng_vbytes), .count(count), .done(done)
    );

    assign eng_valid = pop;
    assign eng_sel   = ctrl.dest;

    // R1: a flush empties the buffer and clears progress
    a_r1_flush_clears: assert property (@(posedge clk) disable iff (rst)
        flush |=> (fill == '0 && count == '0 && !eng_valid));

endmodule

// File: tb/rx_msg_fifo_tb.sv
`timescale 1ns/100ps
module rx_msg_fifo_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_wr = 1'b0;
    logic [7:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        eng_blk_ready = 1'b1;
    logic        eng_valid, eng_last;
    logic [31:0] eng_data, eng_dst;
    logic [1:0]  eng_sel, eng_vbytes;

    int compared = 0;
    int mismatched = 0;
    int cycles = 0;
    int widx = 0;
    int run = 0;

    logic [36:0] exp_q[$];
    int          blk_q[$];

    always #2.5 clk = ~clk;

    rx_msg_fifo dut_i (
        .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .eng_blk_ready(eng_blk_ready),
        .eng_valid(eng_valid), .eng_data(eng_data), .eng_sel(eng_sel),
        .eng_last(eng_last), .eng_vbytes(eng_vbytes), .eng_dst(eng_dst)
    );

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    endtask

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        compared++;
        if (act !== exp) begin
            mismatched++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(posedge clk); #1;
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(posedge clk); #1;
        reg_wr = 1'b0; reg_addr = 8'h00;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        @(posedge clk); #1;
        reg_addr = a;
        @(negedge clk);
        d = reg_rdata;
    endtask

    task automatic put(input logic [31:0] d);
        wr(8'h40 + 8'((widx % 32) * 4), d);
        widx++;
    endtask

    task automatic expect_word(input logic [31:0] d, input logic [1:0] sel,
                               input logic last, input logic [1:0] vb);
        exp_q.push_back({sel, last, vb, d});
    endtask

    task automatic idle(input int n);
        repeat (n) @(posedge clk);
    endtask

    task automatic drained(input string tag);
        chk({tag, " words left"}, 32'(exp_q.size()), 32'd0);
        chk({tag, " blocks left"}, 32'(blk_q.size()), 32'd0);
    endtask

    // monitor / scoreboard
    always @(negedge clk) begin
        if (!rst) begin
            if (eng_valid) begin
                run++;
                if (exp_q.size() == 0) begin
                    compared++; mismatched++;
                    $display("FAIL R8 unexpected word: actual 0x%08h expected none", eng_data);
                end else begin
                    logic [36:0] e;
                    e = exp_q.pop_front();
                    chk("R5 data", eng_data, e[31:0]);
                    chk("R10 sel", 32'(eng_sel), 32'(e[36:35]));
                    chk("R10 last", 32'(eng_last), 32'(e[34]));
                    chk("R10 vbytes", 32'(eng_vbytes), 32'(e[33:32]));
                end
            end else if (run > 0) begin
                if (blk_q.size() == 0) begin
                    compared++; mismatched++;
                    $display("FAIL R6 unexpected block: actual %0d expected none", run);
                end else begin
                    chk("R6 block length", 32'(run), 32'(blk_q.pop_front()));
                end
                run = 0;
            end
        end
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            compared++; mismatched++;
            $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
            summary();
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        idle(3); #1 rst = 1'b0;
        idle(2);

        // R1 / R2: reset state
        rd(8'h00, v);
        chk("R1 reset ctrl", v, 32'h0020_0000);
        chk("R1 reset no valid", 32'(eng_valid), 32'd0);
        rd(8'h10, v);
        chk("R1 reset count", v, 32'd0);

        // AES, 8 words in blocks of 4
        wr(8'h04, 32'd8);
        wr(8'h08, 32'd4);
        wr(8'h0C, 32'h1234_5678);
        wr(8'h00, 32'h31);
        rd(8'h04, v); chk("R11 len readback", v, 32'd8);
        rd(8'h0C, v); chk("R11 dst readback", v, 32'h1234_5678);
        chk("R11 eng_dst", eng_dst, 32'h1234_5678);
        blk_q.push_back(4); blk_q.push_back(4);
        for (int i = 0; i < 8; i++) begin
            expect_word(32'hA000_0000 + 32'(i), 2'd0, 1'b0, 2'd3);
            put(32'hA000_0000 + 32'(i));
        end
        idle(20);
        drained("R5 aes");
        rd(8'h10, v); chk("R8 count", v, 32'd8);
        rd(8'h00, v); chk("R8 done and R2 free", v & 32'h00FF_0300, 32'h0020_0100);

        // R1: flush
        wr(8'h00, 32'h04);
        rd(8'h00, v); chk("R1 flush ctrl", v, 32'h0020_0000);
        rd(8'h10, v); chk("R1 flush count", v, 32'd0);

        // R6: DES with tail block, partial block held back
        wr(8'h04, 32'd6);
        wr(8'h08, 32'd4);
        wr(8'h00, 32'h71);
        for (int i = 0; i < 6; i++) expect_word(32'hB000_0000 + 32'(i), 2'd1, 1'b0, 2'd3);
        for (int i = 0; i < 3; i++) put(32'hB000_0000 + 32'(i));
        idle(10);
        rd(8'h10, v); chk("R5 partial block held", v, 32'd0);
        rd(8'h00, v); chk("R2 free after 3", v[23:16], 32'd29);
        blk_q.push_back(4); blk_q.push_back(2);
        for (int i = 3; i < 6; i++) put(32'hB000_0000 + 32'(i));
        idle(20);
        drained("R6 des");
        rd(8'h10, v); chk("R6 count", v, 32'd6);
        wr(8'h00, 32'h04);

        // R10: hash with valid-byte code, engine not ready at first
        eng_blk_ready = 1'b0;
        wr(8'h04, 32'd5);
        wr(8'h08, 32'h0002_0004);
        wr(8'h00, 32'hB1);
        rd(8'h08, v); chk("R11 blk readback", v, 32'h0002_0004);
        for (int i = 0; i < 5; i++) begin
            expect_word(32'hC000_0000 + 32'(i), 2'd2, i == 4, (i == 4) ? 2'd2 : 2'd3);
            put(32'hC000_0000 + 32'(i));
        end
        idle(10);
        rd(8'h10, v); chk("R5 waits for ready", v, 32'd0);
        blk_q.push_back(4); blk_q.push_back(1);
        eng_blk_ready = 1'b1;
        idle(20);
        drained("R10 hash");
        wr(8'h00, 32'h04);

        // R3: writes dropped without write enable
        wr(8'h00, 32'h10);
        put(32'hDEAD_0000);
        rd(8'h00, v); chk("R3 write disabled", v & 32'h00FF_0200, 32'h0020_0000);

        // R4: overflow on 33rd word
        wr(8'h00, 32'h30);
        for (int i = 0; i < 33; i++) begin
            if (i < 32) expect_word(32'hE000_0000 + 32'(i), 2'd0, 1'b0, 2'd3);
            put(32'hE000_0000 + 32'(i));
        end
        rd(8'h00, v); chk("R4 full and overflow", v & 32'h00FF_0200, 32'h0000_0200);
        // R7: oversized block acts as 32; dropped word never appears
        wr(8'h04, 32'd32);
        wr(8'h08, 32'd100);
        blk_q.push_back(32);
        wr(8'h00, 32'h31);
        idle(60);
        drained("R4 R7 oversize");
        wr(8'h00, 32'h04);
        rd(8'h00, v); chk("R1 flush clears overflow", v[9], 32'd0);

        // R7: block size 0 acts as 1
        wr(8'h04, 32'd3);
        wr(8'h08, 32'd0);
        wr(8'h00, 32'h31);
        blk_q.push_back(1); blk_q.push_back(1); blk_q.push_back(1);
        for (int i = 0; i < 3; i++) begin
            expect_word(32'hF000_0000 + 32'(i), 2'd0, 1'b0, 2'd3);
            put(32'hF000_0000 + 32'(i));
        end
        idle(20);
        drained("R7 size zero");

        // R8: nothing further after done
        put(32'h9000_0000);
        put(32'h9000_0001);
        idle(10);
        rd(8'h10, v); chk("R8 count holds", v, 32'd3);
        rd(8'h00, v); chk("R8 words kept", v[23:16], 32'd30);

        // R9: restart delivers buffered words
        wr(8'h00, 32'h30);
        expect_word(32'h9000_0000, 2'd0, 1'b0, 2'd3);
        expect_word(32'h9000_0001, 2'd0, 1'b0, 2'd3);
        blk_q.push_back(1); blk_q.push_back(1); blk_q.push_back(1);
        wr(8'h00, 32'h31);
        idle(10);
        rd(8'h10, v); chk("R9 count after restart", v, 32'd2);
        expect_word(32'h9000_0002, 2'd0, 1'b0, 2'd3);
        put(32'h9000_0002);
        idle(20);
        drained("R9 restart");
        rd(8'h00, v); chk("R9 done again", v[8], 32'd1);

        summary();
        $finish;
    end

endmodule